// File: doc/BRIEF.md
# Double-Buffered PWM Time Base

This block is the timing core of a multi-channel pulse-width modulator. A 16-bit up counter sets the period. Each of six channels compares the counter against its own duty threshold to make a raw, unconditioned waveform. Later stages handle dead time, masking and polarity.

Software may rewrite the period and the duty thresholds at any moment. Each write lands in a shadow copy. A separate load request arms a transfer. The shadow copies then move into the working registers together, on the clock edge that ends the running period, and the request then withdraws itself. As a result, a period never mixes old and new settings.

A run input gates counting. A clear input forces the counter back to zero, so the first period after start-up has its full length. The block reports the end of every period with a one-cycle pulse, and it shows whether a transfer is still waiting.

Top module: `pwm_dbuf_timebase`

## Requirements
- R1: While `run`=1 and `clr`=0, the counter steps by one per clock from 0 up to the active period value P inclusive, then returns to 0. `period_end` is 1 in exactly the cycle where the count equals P.
- R2: While `run`=0, the counter holds its value, every bit of `pwm_raw` is 0 and `period_end` is 0. When `run` returns to 1, counting resumes from the held value.
- R3: `clr`=1 makes the count 0 in the following cycle and takes precedence over `run`. In its own cycle it forces `period_end` to 0, so no wrap and no transfer take place.
- R4: `pwm_raw[i]` is 1 exactly when `run`=1 and the count is below the active duty of channel i. A duty of 0 gives a constant 0. A duty above P gives 1 for the whole period.
- R5: A period write (`per_wr`) or a duty write (`duty_wr`) changes only the shadow copy. `duty_sel` value i addresses channel i, which drives `pwm_raw[i]`. A `duty_sel` value of 6 or 7 (6 and above) is ignored. The working values change only through a transfer.
- R6: A `load_req` pulse given in a cycle where `period_end`=0 sets `load_pending` from the next cycle on. `load_pending` stays 1 until the transfer.
- R7: A transfer happens on the clock edge that closes a cycle with `period_end`=1, when either `load_pending` or `load_req` is 1. All shadow values are copied together and `load_pending` becomes 0. If `load_req` coincides with `period_end`, the transfer happens at once and `load_pending` never rises.
- R8: A shadow write made in the cycle of a transfer does not join that transfer: the previous shadow value is copied. The newly written value waits for the next load.
- R9: While reset is active and right after it, all shadow and working values and the count are 0, `load_pending` is 0 and every output is 0. The release of `rst_n` is synchronised internally over two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run | input | 1 | Counter enable; outputs low while 0 |
| clr | input | 1 | Counter-clear command |
| per_wr | input | 1 | Write strobe for the shadow period |
| per_wdata | input | 16 | Period value to write |
| duty_wr | input | 1 | Write strobe for one shadow duty |
| duty_sel | input | 3 | Channel index of the duty write |
| duty_wdata | input | 16 | Duty value to write |
| load_req | input | 1 | Arms a shadow-to-active transfer at the next period end |
| pwm_raw | output | 6 | Raw compare outputs, bit i for channel i |
| period_end | output | 1 | High during the last count cycle of each period |
| load_pending | output | 1 | A transfer is armed and has not happened yet |

## Verification
Three events can fall in the same cycle: the period end, a fresh load request, and a shadow write. The bench provokes this by timing `load_req` and a duty write into the very cycle where the count sits at P.

It then judges the result at the ports:
- `load_pending` must never rise.
- The following periods must already run at the new length.
- The channel written in that cycle must still show its previous shadow value, until a second load moves the new one across.

A clear is also placed exactly on the last count, to show that it suppresses both the wrap pulse and the transfer.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;
  localparam int unsigned CNT_W_DEF  = 16;
  localparam int unsigned NUM_CH_DEF = 6;

  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_STEP = 2'd1,
    CNT_WRAP = 2'd2,
    CNT_ZERO = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/pwm_tb_rstsync.sv
module pwm_tb_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter
  import pwm_dbuf_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [CNT_W-1:0] per_act,
  output logic [CNT_W-1:0] cnt,
  output logic             period_end
);
  cnt_op_e          op;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    if (clr)                 op = CNT_ZERO;
    else if (!run)           op = CNT_HOLD;
    else if (cnt_q >= per_act) op = CNT_WRAP;
    else                     op = CNT_STEP;
  end

  always_comb begin
    case (op)
      CNT_STEP: cnt_d = cnt_q + CNT_W'(1);
      CNT_WRAP: cnt_d = '0;
      CNT_ZERO: cnt_d = '0;
      default:  cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt        = cnt_q;
  assign period_end = (op == CNT_WRAP);
endmodule

// File: rtl/pwm_tb_regbank.sv
module pwm_tb_regbank #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned SEL_W  = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         per_wr,
  input  logic [CNT_W-1:0]             per_wdata,
  input  logic                         duty_wr,
  input  logic [SEL_W-1:0]             duty_sel,
  input  logic [CNT_W-1:0]             duty_wdata,
  input  logic                         load_req,
  input  logic                         period_end,
  output logic [CNT_W-1:0]             per_act,
  output logic [NUM_CH-1:0][CNT_W-1:0] duty_act,
  output logic                         load_pending
);
  logic             pend_q, pend_d;
  logic             xfer;
  logic [CNT_W-1:0] per_sh_q, per_sh_d;
  logic [CNT_W-1:0] per_act_q, per_act_d;

  assign xfer   = period_end & (pend_q | load_req);
  assign pend_d = xfer ? 1'b0 : (pend_q | load_req);

  always_comb begin
    per_sh_d  = per_wr ? per_wdata : per_sh_q;
    per_act_d = xfer ? per_sh_q : per_act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      per_sh_q  <= '0;
      per_act_q <= '0;
    end else begin
      pend_q    <= pend_d;
      per_sh_q  <= per_sh_d;
      per_act_q <= per_act_d;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic             wr_en;
    logic [CNT_W-1:0] sh_q, sh_d, act_q, act_d;

    assign wr_en = duty_wr && (duty_sel == SEL_W'(i));

    always_comb begin
      sh_d  = wr_en ? duty_wdata : sh_q;
      act_d = xfer ? sh_q : act_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q  <= '0;
        act_q <= '0;
      end else begin
        sh_q  <= sh_d;
        act_q <= act_d;
      end
    end

    assign duty_act[i] = act_q;
  end

  assign per_act      = per_act_q;
  assign load_pending = pend_q;
endmodule

// File: rtl/pwm_tb_compare.sv
module pwm_tb_compare #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned NUM_CH = 6
) (
  input  logic                         run,
  input  logic [CNT_W-1:0]             cnt,
  input  logic [NUM_CH-1:0][CNT_W-1:0] duty_act,
  output logic [NUM_CH-1:0]            pwm_raw
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_cmp
    assign pwm_raw[i] = run & (cnt < duty_act[i]);
  end
endmodule

// File: rtl/pwm_dbuf_timebase.sv
module pwm_dbuf_timebase #(
  parameter  int unsigned CNT_W  = pwm_dbuf_pkg::CNT_W_DEF,
  parameter  int unsigned NUM_CH = pwm_dbuf_pkg::NUM_CH_DEF,
  localparam int unsigned SEL_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clr,
  input  logic              per_wr,
  input  logic [CNT_W-1:0]  per_wdata,
  input  logic              duty_wr,
  input  logic [SEL_W-1:0]  duty_sel,
  input  logic [CNT_W-1:0]  duty_wdata,
  input  logic              load_req,
  output logic [NUM_CH-1:0] pwm_raw,
  output logic              period_end,
  output logic              load_pending
);
  logic                         rst_sync_n;
  logic [CNT_W-1:0]             cnt;
  logic [CNT_W-1:0]             per_act;
  logic [NUM_CH-1:0][CNT_W-1:0] duty_act;

  pwm_tb_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pwm_tb_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .run        (run),
    .clr        (clr),
    .per_act    (per_act),
    .cnt        (cnt),
    .period_end (period_end)
  );

  pwm_tb_regbank #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .per_wr       (per_wr),
    .per_wdata    (per_wdata),
    .duty_wr      (duty_wr),
    .duty_sel     (duty_sel),
    .duty_wdata   (duty_wdata),
    .load_req     (load_req),
    .period_end   (period_end),
    .per_act      (per_act),
    .duty_act     (duty_act),
    .load_pending (load_pending)
  );

  pwm_tb_compare #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_cmp (
    .run      (run),
    .cnt      (cnt),
    .duty_act (duty_act),
    .pwm_raw  (pwm_raw)
  );
endmodule

// File: rtl/pwm_dbuf_chk.sv
module pwm_dbuf_chk #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned NUM_CH = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              clr,
  input logic              load_req,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  per_act,
  input logic              period_end,
  input logic              load_pending,
  input logic [NUM_CH-1:0] pwm_raw
);
  // R1
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> (cnt == '0));

  // R1
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && !period_end) |=> (cnt == $past(cnt) + CNT_W'(1)));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(cnt));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (pwm_raw == '0 && !period_end));

  // R3
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

  // R5
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> $stable(per_act));

  // R6
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && !period_end) |=> load_pending);

  // R7
  pend_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> !load_pending);
endmodule

bind pwm_dbuf_timebase pwm_dbuf_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .run          (run),
  .clr          (clr),
  .load_req     (load_req),
  .cnt          (cnt),
  .per_act      (per_act),
  .period_end   (period_end),
  .load_pending (load_pending),
  .pwm_raw      (pwm_raw)
);

// File: tb/sim_pwm_dbuf_timebase.sv
module sim_pwm_dbuf_timebase;
  localparam int CNT_W  = 16;
  localparam int NUM_CH = 6;
  localparam int SEL_W  = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              run, clr, per_wr, duty_wr, load_req;
  logic [CNT_W-1:0]  per_wdata, duty_wdata;
  logic [SEL_W-1:0]  duty_sel;
  logic [NUM_CH-1:0] pwm_raw;
  logic              period_end, load_pending;

  always #4 clk = ~clk;

  pwm_dbuf_timebase u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .clr(clr),
    .per_wr(per_wr), .per_wdata(per_wdata),
    .duty_wr(duty_wr), .duty_sel(duty_sel), .duty_wdata(duty_wdata),
    .load_req(load_req), .pwm_raw(pwm_raw),
    .period_end(period_end), .load_pending(load_pending)
  );

  typedef struct {
    int         kind;
    logic [15:0] val;
    string      tag;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  int ed[NUM_CH];

  logic             nx_pw = 0, nx_dw = 0;
  logic [CNT_W-1:0] nx_pd = '0, nx_dd = '0;
  logic [SEL_W-1:0] nx_ds = '0;

  task automatic push(input int kind, input logic [15:0] val, input string tag);
    item_t it;
    it.kind = kind; it.val = val; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic expect3(input logic [NUM_CH-1:0] rv, input logic pe,
                         input logic pd, input string tag);
    push(0, 16'(rv), tag);
    push(1, 16'(pe), tag);
    push(2, 16'(pd), tag);
  endtask

  function automatic logic [NUM_CH-1:0] raw_of(input int c);
    logic [NUM_CH-1:0] r;
    for (int i = 0; i < NUM_CH; i++) r[i] = (c < ed[i]);
    return r;
  endfunction

  task automatic tick(input logic r, input logic c, input logic l);
    @(negedge clk);
    run = r; clr = c; load_req = l;
    per_wr = nx_pw; per_wdata = nx_pd;
    duty_wr = nx_dw; duty_sel = nx_ds; duty_wdata = nx_dd;
    nx_pw = 0; nx_dw = 0;
  endtask

  task automatic set_duty(input int ch, input int v);
    nx_dw = 1; nx_ds = SEL_W'(ch); nx_dd = CNT_W'(v);
  endtask

  // monitor: pops expected items and compares them with the ports
  always @(negedge clk) begin
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      string nm;
      it = q.pop_front();
      case (it.kind)
        0:       begin act = 16'(pwm_raw);      nm = "pwm_raw";      end
        1:       begin act = 16'(period_end);   nm = "period_end";   end
        default: begin act = 16'(load_pending); nm = "load_pending"; end
      endcase
      n_chk++;
      if (act !== it.val) begin
        n_bad++;
        $display("FAIL %s %s actual=%h expected=%h t=%0t",
                 it.tag, nm, act, it.val, $time);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; run = 0; clr = 0; load_req = 0;
    per_wr = 0; per_wdata = '0; duty_wr = 0; duty_sel = '0; duty_wdata = '0;
    for (int i = 0; i < NUM_CH; i++) ed[i] = 0;

    // R9: outputs held low during reset
    tick(0, 0, 0); expect3('0, 0, 0, "R9");
    tick(0, 0, 0); expect3('0, 0, 0, "R9");
    @(negedge clk); rst_n = 1;
    repeat (3) begin tick(0, 0, 0); expect3('0, 0, 0, "R9"); end

    // R5: shadow writes while stopped
    nx_pw = 1; nx_pd = 16'd4; tick(0, 0, 0);
    set_duty(0, 2); tick(0, 0, 0);
    set_duty(1, 0); tick(0, 0, 0);
    set_duty(2, 5); tick(0, 0, 0);
    set_duty(3, 4); tick(0, 0, 0);
    set_duty(4, 1); tick(0, 0, 0);
    set_duty(5, 3); tick(0, 0, 0);

    // R6: load request arms pending next cycle
    tick(0, 0, 1); expect3('0, 0, 0, "R6");
    repeat (3) begin tick(0, 0, 0); expect3('0, 0, 1, "R6"); end

    // R5: first run cycle still sees zero actives (per 0 -> immediate end)
    tick(1, 0, 0); expect3('0, 1, 1, "R5");
    ed = '{2, 0, 5, 4, 1, 3};

    // R1 R4 R7: period 4 with new duties, pending cleared
    for (int k = 0; k < 12; k++) begin
      tick(1, 0, 0);
      expect3(raw_of(k % 5), (k % 5) == 4, 0, "R1");
    end

    // R2: stop holds count 2, outputs low
    repeat (3) begin tick(0, 0, 0); expect3('0, 0, 0, "R2"); end
    for (int c = 2; c < 5; c++) begin
      tick(1, 0, 0); expect3(raw_of(c), c == 4, 0, "R2");
    end
    tick(1, 0, 0); expect3(raw_of(0), 0, 0, "R2");

    // R3: clear on the last count suppresses end pulse
    for (int c = 1; c < 4; c++) begin
      tick(1, 0, 0); expect3(raw_of(c), 0, 0, "R4");
    end
    tick(1, 1, 0); expect3(raw_of(4), 0, 0, "R3");
    for (int k = 0; k < 6; k++) begin
      tick(1, 0, 0); expect3(raw_of(k % 5), (k % 5) == 4, 0, "R3");
    end

    // R5: running shadow writes, invalid select ignored
    nx_pw = 1; nx_pd = 16'd2; tick(1, 0, 0); expect3(raw_of(1), 0, 0, "R5");
    set_duty(0, 1); tick(1, 0, 0); expect3(raw_of(2), 0, 0, "R5");
    set_duty(6, 16'hFFFF); tick(1, 0, 0); expect3(raw_of(3), 0, 0, "R5");
    tick(1, 0, 0); expect3(raw_of(4), 1, 0, "R5");
    for (int c = 0; c < 4; c++) begin
      tick(1, 0, 0); expect3(raw_of(c), 0, 0, "R5");
    end

    // R7 R8: load request and duty write in the period-end cycle
    set_duty(1, 3); tick(1, 0, 1); expect3(raw_of(4), 1, 0, "R7");
    ed = '{1, 0, 5, 4, 1, 3};
    for (int k = 0; k < 6; k++) begin
      tick(1, 0, 0); expect3(raw_of(k % 3), (k % 3) == 2, 0, "R8");
    end

    // R6 R8: second load brings the late write across
    tick(1, 0, 1); expect3(raw_of(0), 0, 0, "R6");
    tick(1, 0, 0); expect3(raw_of(1), 0, 1, "R6");
    tick(1, 0, 0); expect3(raw_of(2), 1, 1, "R7");
    ed = '{1, 3, 5, 4, 1, 3};
    for (int k = 0; k < 4; k++) begin
      tick(1, 0, 0); expect3(raw_of(k % 3), (k % 3) == 2, 0, "R8");
    end

    tick(0, 0, 0);
    #3;
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule